// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Framer for an FSK Modulator

This block sits between a host microcontroller and a frequency-shift-keyed modulator. The host writes bytes into a one-byte holding register. The block turns those bytes into a single serial bit stream at a fixed bit rate, and a downstream modulator converts that stream to tones. The bit rate comes from a divider of the system clock. With the default divider, a 48 MHz clock gives 1200 bit/s.

A mode bit in a setup register picks one of two framings:

- **Unframed (synchronous):** bytes leave back to back, LSB first.
- **Framed (asynchronous):** each byte is wrapped in a space-level start bit and a mark-level stop bit.

The mode is sampled each time a new character begins. Two status flags guide the host:

- **Ready:** asks for the next byte.
- **Underflow:** a sticky flag that records a character boundary reached with no new byte waiting.

On underflow, framed mode parks the line at mark until a byte arrives. Unframed mode sends the held byte again.

Top module: `fsk_tx_serializer`

## Requirements
- R1: After reset the mode is framed (asynchronous), `tx_bit` is 1, ready is 1 and underflow is 0.
- R2: Every serial bit lasts exactly `CLK_DIV` clock cycles, and `tx_bit` changes only on a bit-rate tick.
- R3: In framed mode a character is ten bits: one 0 (start), then data bits 0 to 7 LSB first, then one 1 (stop).
- R4: In unframed mode a character is eight bits, data bit 0 first, with no start or stop bit; consecutive characters follow with no gap.
- R5: Writing setup (address 1) stores `host_wdata[1]` as the mode, where 1 is framed and 0 is unframed. The mode is sampled only when a character begins, so a character already on the line keeps its framing.
- R6: Ready drops in the cycle after a data write (address 0). It rises when the held byte is copied into the transmitter at a character start. If a write and a copy fall in the same cycle, the write wins.
- R7: Underflow is set when a character ends while ready is 1. It stays set through data writes and is cleared only by a status read. If a new underflow and a status read coincide, the flag is left set.
- R8: After a framed-mode underflow, `tx_bit` stays 1 until a byte is written. The next character then starts on the following tick.
- R9: After an unframed-mode underflow, the byte still held in the data register is sent again.
- R10: `host_status` bit 7 is underflow, bit 6 is ready, and bits 5 to 0 read 0.
- R11: A data write while ready is 0 replaces the pending byte. Only the last byte written before the copy is sent.
- R12: Before the first data write after reset, the line idles at 1 and underflow is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 selects the data register, 1 selects the setup register |
| host_wdata | input | 8 | Host write data |
| host_stat_rd | input | 1 | Status read strobe; clears underflow after this cycle |
| host_status | output | 8 | Status: bit 7 underflow, bit 6 ready |
| tx_bit | output | 1 | Serial bit to the modulator |

## Verification
The bench builds the block with `CLK_DIV = 8`, so a framed character takes 80 cycles. This lets hundreds of characters, underflows in both modes and mode switches partway through a character fit in a short run. The small divider also puts writes, status reads and copies on the same edge as a tick within easy reach of random timing, and that is where the write-wins and set-wins ordering rules apply. A cycle-level reference model checks every cycle. Directed captures of whole characters check the framing, the resend and the last-write-wins behaviour.

// File: rtl/fsk_ser_pkg.sv
package fsk_ser_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAMED_LEN = 10;
    localparam int RAW_LEN    = 8;
    localparam int IDX_W      = 4;
    localparam int MODE_BIT   = 1;

    typedef enum logic {
        MODE_RAW    = 1'b0,
        MODE_FRAMED = 1'b1
    } tx_mode_e;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    typedef enum logic {
        ADDR_DATA  = 1'b0,
        ADDR_SETUP = 1'b1
    } host_addr_e;

    typedef struct packed {
        logic       underflow;
        logic       ready;
        logic [5:0] rsvd;
    } tx_status_t;

    // Index of the last bit slot of a character in the given mode
    function automatic logic [IDX_W-1:0] last_slot(input tx_mode_e m);
        return (m == MODE_FRAMED) ? IDX_W'(FRAMED_LEN - 1) : IDX_W'(RAW_LEN - 1);
    endfunction

    // Line level for slot idx of a character carrying byte b
    function automatic logic slot_level(input tx_mode_e m,
                                        input logic [BYTE_W-1:0] b,
                                        input logic [IDX_W-1:0] idx);
        logic lvl;
        if (m == MODE_FRAMED) begin
            if (idx == '0)
                lvl = 1'b0;
            else if (idx >= IDX_W'(FRAMED_LEN - 1))
                lvl = 1'b1;
            else
                lvl = b[3'(idx - 1'b1)];
        end else begin
            lvl = b[3'(idx)];
        end
        return lvl;
    endfunction

endpackage

// File: rtl/fsk_baud_tick.sv
module fsk_baud_tick
    import fsk_ser_pkg::*;
#(
    parameter int CLK_DIV = 40000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == CNT_TOP)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CNT_TOP);

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));
endmodule

// File: rtl/fsk_host_regs.sv
module fsk_host_regs
    import fsk_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              stat_rd,
    input  logic              load,
    input  logic              uf_evt,
    output logic [BYTE_W-1:0] hold_byte,
    output tx_mode_e          mode,
    output logic              ready,
    output tx_status_t        status
);
    logic underflow;
    logic data_wr;
    logic setup_wr;

    assign data_wr  = wr && (addr == ADDR_DATA);
    assign setup_wr = wr && (addr == ADDR_SETUP);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_byte <= '0;
            mode      <= MODE_FRAMED;
            ready     <= 1'b1;
            underflow <= 1'b0;
        end else begin
            if (data_wr)
                hold_byte <= wdata;
            if (setup_wr)
                mode <= tx_mode_e'(wdata[MODE_BIT]);
            if (data_wr)
                ready <= 1'b0;
            else if (load)
                ready <= 1'b1;
            if (uf_evt)
                underflow <= 1'b1;
            else if (stat_rd)
                underflow <= 1'b0;
        end
    end

    always_comb begin
        status           = '0;
        status.underflow = underflow;
        status.ready     = ready;
    end

    // R6
    wr_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> !ready);

    // R7
    uf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && !stat_rd) |=> underflow);

    // R7
    uf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !uf_evt) |=> !underflow);
endmodule

// File: rtl/fsk_char_shifter.sv
module fsk_char_shifter
    import fsk_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tx_mode_e          mode,
    input  logic              fresh,
    input  logic [BYTE_W-1:0] hold_byte,
    output logic              load,
    output logic              reload,
    output logic              uf_evt,
    output logic              tx_bit
);
    sh_state_e         state;
    tx_mode_e          cur_mode;
    logic [BYTE_W-1:0] cur_byte;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  nidx;
    logic              at_end;

    assign at_end = (state == SH_RUN) && (idx == last_slot(cur_mode));
    assign nidx   = idx + 1'b1;
    assign load   = tick && fresh && ((state == SH_IDLE) || at_end);
    assign reload = tick && at_end && !fresh && (mode == MODE_RAW);
    assign uf_evt = tick && at_end && !fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            cur_mode <= MODE_FRAMED;
            cur_byte <= '0;
            idx      <= '0;
            tx_bit   <= 1'b1;
        end else if (load || reload) begin
            state    <= SH_RUN;
            cur_mode <= mode;
            cur_byte <= hold_byte;
            idx      <= '0;
            tx_bit   <= slot_level(mode, hold_byte, '0);
        end else if (tick && at_end) begin
            state  <= SH_IDLE;
            tx_bit <= 1'b1;
        end else if (tick && (state == SH_RUN)) begin
            idx    <= nidx;
            tx_bit <= slot_level(cur_mode, cur_byte, nidx);
        end
    end

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tx_bit));

    // R8
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE) |-> tx_bit);

    // R4
    raw_first_chk: assert property (@(posedge clk) disable iff (rst)
        ((load || reload) && (mode == MODE_RAW)) |=> (tx_bit == $past(hold_byte[0])));
endmodule

// File: rtl/fsk_tx_serializer.sv
module fsk_tx_serializer
    import fsk_ser_pkg::*;
#(
    parameter int CLK_DIV = 40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_stat_rd,
    output logic [BYTE_W-1:0] host_status,
    output logic              tx_bit
);
    logic              tick;
    logic              load;
    logic              reload;
    logic              uf_evt;
    logic              ready;
    logic [BYTE_W-1:0] hold_byte;
    tx_mode_e          mode;
    tx_status_t        status;

    fsk_baud_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fsk_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .stat_rd   (host_stat_rd),
        .load      (load),
        .uf_evt    (uf_evt),
        .hold_byte (hold_byte),
        .mode      (mode),
        .ready     (ready),
        .status    (status)
    );

    fsk_char_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (mode),
        .fresh     (!ready),
        .hold_byte (hold_byte),
        .load      (load),
        .reload    (reload),
        .uf_evt    (uf_evt),
        .tx_bit    (tx_bit)
    );

    assign host_status = status;

    // R3
    framed_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (mode == MODE_FRAMED)) |=> !tx_bit);

    // R9
    resend_flags_uf_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> host_status[7]);

    // R10
    status_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        host_status[5:0] == 6'd0);
endmodule

// File: tb/fsk_tx_serializer_tb.sv
module fsk_tx_serializer_tb;
    localparam int DIV      = 8;
    localparam int CLK_HALF = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic       host_addr;
    logic [7:0] host_wdata;
    logic       host_stat_rd;
    logic [7:0] host_status;
    logic       tx_bit;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_HALF) clk = ~clk;

    fsk_tx_serializer #(.CLK_DIV(DIV)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_stat_rd (host_stat_rd),
        .host_status  (host_status),
        .tx_bit       (tx_bit)
    );

    // Expected character image: framed = {1, byte, 0}, raw = byte
    function automatic logic [9:0] make_frame(input logic framed, input logic [7:0] b);
        return framed ? {1'b1, b, 1'b0} : {2'b11, b};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, stepped at each rising edge
    int         m_cnt;
    logic       m_ready, m_uf, m_mode, m_run, m_out, m_start;
    logic [7:0] m_data;
    logic [9:0] m_frame;
    int         m_pos, m_len;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ready = 1; m_uf = 0; m_mode = 1; m_run = 0;
            m_out = 1; m_start = 0; m_data = 0; m_frame = 0; m_pos = 0; m_len = 10;
        end else begin
            logic tk, last, ld, rs, ufe;
            tk   = (m_cnt == DIV - 1);
            last = m_run && (m_pos == m_len - 1);
            ld = 0; rs = 0; ufe = 0; m_start = 0;
            if (tk) begin
                if ((!m_run || last) && !m_ready) ld = 1;
                else if (last) begin ufe = 1; rs = (m_mode == 1'b0); end
            end
            if (ld || rs) begin
                m_len = m_mode ? 10 : 8;
                m_frame = make_frame(m_mode, m_data);
                m_pos = 0; m_run = 1; m_out = m_frame[0]; m_start = 1;
            end else if (tk && last) begin
                m_run = 0; m_out = 1;
            end else if (tk && m_run) begin
                m_pos++; m_out = m_frame[m_pos];
            end
            if (ufe) m_uf = 1; else if (host_stat_rd) m_uf = 0;
            if (host_wr && !host_addr) begin m_data = host_wdata; m_ready = 0; end
            else if (ld) m_ready = 1;
            if (host_wr && host_addr) m_mode = host_wdata[1];
            m_cnt = tk ? 0 : m_cnt + 1;
        end
    end

    // Continuous comparison against the model (R3/R4 line, R6/R7 flags)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3/R4 line vs model", {31'd0, tx_bit}, {31'd0, m_out});
            chk("R6/R7 status vs model", {24'd0, host_status}, {24'd0, m_uf, m_ready, 6'd0});
        end
    end

    task automatic wr_reg(input logic a, input logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd_stat();
        host_stat_rd = 1;
        @(negedge clk);
        host_stat_rd = 0;
    endtask

    // Wait for a character start, then sample n bits mid-period
    task automatic grab(input int n, output logic [9:0] bits);
        bits = '1;
        do @(negedge clk); while (!m_start);
        for (int k = 0; k < n; k++) begin
            repeat (k == 0 ? DIV / 2 : DIV) @(negedge clk);
            bits[k] = tx_bit;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [9:0] got;
        void'($urandom(32'd605));
        rst = 1; host_wr = 0; host_addr = 0; host_wdata = 0; host_stat_rd = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1, R10: reset state
        chk("R1 tx_bit after reset", {31'd0, tx_bit}, 32'd1);
        chk("R10 status after reset", {24'd0, host_status}, 32'h40);
        // R12: idle with no data
        repeat (5 * DIV) @(negedge clk);
        chk("R12 idle line", {31'd0, tx_bit}, 32'd1);
        chk("R12 no underflow", {31'd0, host_status[7]}, 32'd0);

        // R6 then R3/R2 framed character
        wr_reg(0, 8'hA5);
        chk("R6 ready low after write", {31'd0, host_status[6]}, 32'd0);
        grab(10, got);
        chk("R3 framed character", {22'd0, got}, {22'd0, make_frame(1, 8'hA5)});
        chk("R6 ready high after copy", {31'd0, host_status[6]}, 32'd1);

        // R7/R8 underflow in framed mode
        repeat (3 * DIV) @(negedge clk);
        chk("R8 mark after underflow", {31'd0, tx_bit}, 32'd1);
        chk("R7 underflow set", {31'd0, host_status[7]}, 32'd1);
        wr_reg(0, 8'h3C);
        chk("R7 write keeps underflow", {31'd0, host_status[7]}, 32'd1);
        grab(10, got);
        chk("R8 resumes with new byte", {22'd0, got}, {22'd0, make_frame(1, 8'h3C)});
        rd_stat();
        chk("R7 read clears underflow", {31'd0, host_status[7]}, 32'd0);

        // R11: two writes before the copy
        wr_reg(0, 8'h11);
        wr_reg(0, 8'h22);
        grab(10, got);
        chk("R11 last write wins", {22'd0, got}, {22'd0, make_frame(1, 8'h22)});

        // R5: switch to raw while a framed character is on the line
        wr_reg(0, 8'h5A);
        do @(negedge clk); while (!m_start);
        wr_reg(1, 8'h00);
        wr_reg(0, 8'h96);
        repeat (10 * DIV) @(negedge clk);
        // R4: raw character, then R9 resend of the same byte
        grab(8, got);
        chk("R4/R5 raw character", {24'd0, got[7:0]}, 32'h96);
        grab(8, got);
        chk("R9 raw resend", {24'd0, got[7:0]}, 32'h96);
        chk("R9 underflow on resend", {31'd0, host_status[7]}, 32'd1);
        rd_stat();

        // Random traffic checked by the model
        for (int i = 0; i < 400; i++) begin
            int act;
            act = $urandom_range(0, 9);
            if (act < 6) wr_reg(0, 8'($urandom));
            else if (act == 6) wr_reg(1, {6'd0, 1'($urandom), 1'b0});
            else if (act == 7) rd_stat();
            repeat ($urandom_range(0, 60)) @(negedge clk);
        end
        repeat (20 * DIV) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule